// File: doc/BRIEF.md
# Boot Failure Supervisor

This block runs once after every system reset and decides whether the system may go on booting or has to switch itself off. It first puts the system in a quiet posture: interrupts are held masked, the power-hold output is driven low and the watchdog is stopped. It then starts the watchdog with its long timeout and waits a fixed settling interval. Only after that does it compare two inputs. The first is the reset-cause flag, which says whether a watchdog bite caused the last reset. The second is a retained boot-attempt flag.

The boot-attempt flag is stored in a flip-flop that is cleared only by a full power-on reset. An ordinary system reset, including a watchdog reset, leaves it alone. A proceed verdict sets the flag, and software clears it once the boot has been shown to work. If a watchdog reset finds the flag still set, the earlier attempt hung. The block then declares a terminal failure. It drops power hold, stops the watchdog and clears the flag, so that the next external power-up starts a fresh attempt. It then waits in that state until power goes away.

Top module: `boot_supervisor`

## Requirements
- R1: While `rst` is high the outputs are `irq_mask`=1, `pwr_hold`=0, `wdt_en`=0, `boot_ok`=0 and `fail`=0.
- R2: `por` high clears `attempt_flag`. A reset on `rst` alone leaves `attempt_flag` unchanged.
- R3: On the first clock edge after `rst` is released, `wdt_en` becomes 1 with `wdt_tmo` equal to the long timeout parameter, while `pwr_hold` stays 0. The verdict (`boot_ok` or `fail`) appears exactly ARM_WAIT+2 edges after release and not before.
- R4: When `wd_cause`=0, the verdict is proceed: `boot_ok` pulses and `attempt_flag` becomes 1.
- R5: When `wd_cause`=1 and `attempt_flag`=0, the verdict is also proceed, with `boot_ok` pulsing and `attempt_flag` becoming 1.
- R6: When `wd_cause`=1 and `attempt_flag`=1, the verdict is failure: `fail` rises and `attempt_flag` is cleared on the same edge.
- R7: In failure, `pwr_hold`=0, `wdt_en`=0 and `irq_mask`=1. `fail` stays 1 until the next `rst`, whatever the other inputs do.
- R8: `boot_ok` is high for exactly one cycle. From that cycle on, `pwr_hold`=1, `irq_mask`=0 and `wdt_en`=1.
- R9: A `sw_clr` pulse clears `attempt_flag` only after a proceed verdict. In any other state it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset; restarts the decision sequence |
| por | input | 1 | Synchronous active-high power-on reset; also clears the retained flag |
| wd_cause | input | 1 | 1 when the last reset came from the watchdog |
| sw_clr | input | 1 | Software write that clears the boot-attempt flag |
| irq_mask | output | 1 | 1 while interrupts must stay masked |
| pwr_hold | output | 1 | Power-hold drive; 0 lets the supply turn off |
| wdt_en | output | 1 | Watchdog run enable |
| wdt_tmo | output | TMO_W | Timeout value loaded into the watchdog |
| boot_ok | output | 1 | One-cycle proceed verdict |
| fail | output | 1 | Level terminal-failure verdict |
| attempt_flag | output | 1 | Retained boot-attempt flag |

## Verification
The bench runs a long chain of boots that share the retained flag. In each boot the power-on reset, the reset cause and the software clear are drawn at random, so all three verdict paths occur in many orders. Boots with a cold start against a watchdog cause show that the power-on clear is what separates R5 from R6. Boots that skip the software clear, followed by a watchdog cause, drive the failure path. A `sw_clr` pulse during arming, followed by a watchdog cause, shows whether the clear is ignored outside the run state: if it is ignored the verdict is failure, if it is wrongly honoured the verdict is proceed.

// File: rtl/bsup_pkg.sv
package bsup_pkg;
  typedef enum logic [2:0] {
    ST_QUIET = 3'd0,
    ST_ARM   = 3'd1,
    ST_CHECK = 3'd2,
    ST_PASS  = 3'd3,
    ST_RUN   = 3'd4,
    ST_FAIL  = 3'd5
  } bsup_state_e;
endpackage

// File: rtl/bsup_arm_timer.sv
// Counts the settling interval after the watchdog is armed.
module bsup_arm_timer #(
  parameter int WAIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (WAIT > 1) ? $clog2(WAIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(WAIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = run && (cnt == LAST);
endmodule

// File: rtl/bsup_retained.sv
// Boot-attempt flag; survives system resets, cleared only by power-on.
module bsup_retained (
  input  logic clk,
  input  logic por,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (por) q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/bsup_ctrl.sv
// Decision sequencer with registered Moore outputs.
module bsup_ctrl
  import bsup_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        arm_done,
  input  logic        wd_cause,
  input  logic        sticky,
  input  logic        sw_clr,
  output bsup_state_e state,
  output logic        sticky_set,
  output logic        sticky_clr,
  output logic        irq_mask,
  output logic        pwr_hold,
  output logic        wdt_en,
  output logic        boot_ok,
  output logic        fail
);
  bsup_state_e nxt;
  logic        hung;

  assign hung = wd_cause && sticky;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_QUIET: nxt = ST_ARM;
      ST_ARM:   nxt = arm_done ? ST_CHECK : ST_ARM;
      ST_CHECK: nxt = hung ? ST_FAIL : ST_PASS;
      ST_PASS:  nxt = ST_RUN;
      ST_RUN:   nxt = ST_RUN;
      ST_FAIL:  nxt = ST_FAIL;
      default:  nxt = ST_QUIET;
    endcase
  end

  assign sticky_set = !rst && (state == ST_CHECK) && !hung;
  assign sticky_clr = !rst && (((state == ST_CHECK) && hung) ||
                               (sw_clr && ((state == ST_RUN) || (state == ST_PASS))));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_QUIET;
      irq_mask <= 1'b1;
      pwr_hold <= 1'b0;
      wdt_en   <= 1'b0;
      boot_ok  <= 1'b0;
      fail     <= 1'b0;
    end else begin
      state    <= nxt;
      irq_mask <= !((nxt == ST_PASS) || (nxt == ST_RUN));
      pwr_hold <= (nxt == ST_PASS) || (nxt == ST_RUN);
      wdt_en   <= (nxt == ST_ARM) || (nxt == ST_CHECK) ||
                  (nxt == ST_PASS) || (nxt == ST_RUN);
      boot_ok  <= (nxt == ST_PASS);
      fail     <= (nxt == ST_FAIL);
    end
  end
endmodule

// File: rtl/boot_supervisor.sv
module boot_supervisor #(
  parameter int              ARM_WAIT = 4,
  parameter int              TMO_W    = 32,
  parameter logic [TMO_W-1:0] TMO_LONG = 32'hFFE1_FFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             wd_cause,
  input  logic             sw_clr,
  output logic             irq_mask,
  output logic             pwr_hold,
  output logic             wdt_en,
  output logic [TMO_W-1:0] wdt_tmo,
  output logic             boot_ok,
  output logic             fail,
  output logic             attempt_flag
);
  import bsup_pkg::*;

  bsup_state_e state;
  logic        arm_done;
  logic        sticky_set;
  logic        sticky_clr;

  bsup_arm_timer #(.WAIT(ARM_WAIT)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (state == ST_ARM),
    .done(arm_done)
  );

  bsup_retained u_flag (
    .clk  (clk),
    .por  (por),
    .set_i(sticky_set),
    .clr_i(sticky_clr),
    .q    (attempt_flag)
  );

  bsup_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .arm_done  (arm_done),
    .wd_cause  (wd_cause),
    .sticky    (attempt_flag),
    .sw_clr    (sw_clr),
    .state     (state),
    .sticky_set(sticky_set),
    .sticky_clr(sticky_clr),
    .irq_mask  (irq_mask),
    .pwr_hold  (pwr_hold),
    .wdt_en    (wdt_en),
    .boot_ok   (boot_ok),
    .fail      (fail)
  );

  assign wdt_tmo = TMO_LONG;
endmodule

// File: rtl/boot_supervisor_chk.sv
module boot_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic irq_mask,
  input logic pwr_hold,
  input logic wdt_en,
  input logic boot_ok,
  input logic fail,
  input logic attempt_flag
);
  assert_boot_ok_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    boot_ok |=> !boot_ok);
  assert_run_posture_R8: assert property (@(posedge clk) disable iff (rst)
    boot_ok |-> (pwr_hold && !irq_mask && wdt_en));
  assert_fail_holds_R7: assert property (@(posedge clk) disable iff (rst)
    fail |=> fail);
  assert_fail_posture_R7: assert property (@(posedge clk) disable iff (rst)
    fail |-> (!pwr_hold && !wdt_en && irq_mask));
  assert_fail_clears_flag_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> !attempt_flag);
  assert_proceed_sets_flag_R4: assert property (@(posedge clk) disable iff (rst)
    boot_ok |-> attempt_flag);
  assert_armed_before_verdict_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(fail) || boot_ok) |-> $past(wdt_en));
  assert_verdict_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(boot_ok && fail));
endmodule

bind boot_supervisor boot_supervisor_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .irq_mask    (irq_mask),
  .pwr_hold    (pwr_hold),
  .wdt_en      (wdt_en),
  .boot_ok     (boot_ok),
  .fail        (fail),
  .attempt_flag(attempt_flag)
);

// File: tb/sim_boot_supervisor.sv
module sim_boot_supervisor;
  localparam int ARM_WAIT = 4;
  localparam int TMO_W = 32;
  localparam logic [TMO_W-1:0] TMO_LONG = 32'hFFE1_FFFF;

  logic clk = 1'b0;
  logic rst = 1'b1, por = 1'b1, wd_cause = 1'b0, sw_clr = 1'b0;
  logic irq_mask, pwr_hold, wdt_en, boot_ok, fail, attempt_flag;
  logic [TMO_W-1:0] wdt_tmo;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic flag_m = 1'b0;

  always #10 clk = ~clk;

  boot_supervisor #(.ARM_WAIT(ARM_WAIT), .TMO_W(TMO_W), .TMO_LONG(TMO_LONG)) u0 (
    .clk(clk), .rst(rst), .por(por), .wd_cause(wd_cause), .sw_clr(sw_clr),
    .irq_mask(irq_mask), .pwr_hold(pwr_hold), .wdt_en(wdt_en), .wdt_tmo(wdt_tmo),
    .boot_ok(boot_ok), .fail(fail), .attempt_flag(attempt_flag));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic exp_fail(input logic cause, input logic flag);
    return cause && flag;
  endfunction

  // One complete boot; arm_clr pulses sw_clr during arming, run_clr after proceed.
  task automatic boot(input logic cold, input logic cause, input logic arm_clr,
                      input logic run_clr);
    logic vf;
    rst = 1'b1; por = cold; wd_cause = cause; sw_clr = 1'b0;
    step(); step();
    if (cold) flag_m = 1'b0;
    chk("R1 irq_mask", irq_mask, 1); chk("R1 pwr_hold", pwr_hold, 0);
    chk("R1 wdt_en", wdt_en, 0); chk("R1 verdict", {boot_ok, fail}, 0);
    chk("R2 flag across reset", attempt_flag, flag_m);
    rst = 1'b0; por = 1'b0;
    step();
    chk("R3 armed", wdt_en, 1); chk("R3 timeout", wdt_tmo, TMO_LONG);
    chk("R3 hold low", pwr_hold, 0);
    if (arm_clr) begin sw_clr = 1'b1; step(); sw_clr = 1'b0; end
    else step();
    for (int i = 0; i < ARM_WAIT - 1; i++) step();
    chk("R3 no early verdict", {boot_ok, fail}, 0);
    chk("R9 clear ignored while arming", attempt_flag, flag_m);
    step();
    vf = exp_fail(cause, flag_m);
    flag_m = !vf;
    if (vf) begin
      chk("R6 fail", fail, 1); chk("R6 flag cleared", attempt_flag, 0);
      chk("R7 posture", {pwr_hold, wdt_en, irq_mask}, 3'b001);
      sw_clr = 1'b1; wd_cause = ~cause;
      for (int i = 0; i < 5; i++) step();
      sw_clr = 1'b0;
      chk("R7 fail persists", fail, 1);
      chk("R7 posture persists", {pwr_hold, wdt_en, irq_mask}, 3'b001);
    end else begin
      chk(cause ? "R5 proceed" : "R4 proceed", {boot_ok, fail}, 2'b10);
      chk(cause ? "R5 flag set" : "R4 flag set", attempt_flag, 1);
      step();
      chk("R8 pulse one cycle", boot_ok, 0);
      chk("R8 run posture", {pwr_hold, wdt_en, irq_mask}, 3'b110);
      if (run_clr) begin
        sw_clr = 1'b1; step(); sw_clr = 1'b0;
        flag_m = 1'b0;
        chk("R9 software clear", attempt_flag, 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    // directed corners
    boot(1, 0, 0, 0);   // R4 cold, leaves flag set (hang)
    boot(0, 1, 0, 0);   // R6 watchdog with flag set
    boot(0, 1, 0, 0);   // R5 flag was cleared by failure
    boot(0, 0, 0, 1);   // R4 then software clear
    boot(0, 1, 0, 0);   // R5
    boot(1, 1, 0, 0);   // R2 cold start clears flag -> proceed
    boot(0, 1, 1, 0);   // R9 clear during arming ignored -> fail
    // random
    for (int k = 0; k < 200; k++) begin
      boot(($urandom % 4) == 0, $urandom % 2, ($urandom % 5) == 0, ($urandom % 2) == 1);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule